// File: doc/BRIEF.md
# Fractional SPI Serial-Clock Generator

This block makes an SPI serial clock from a fast base clock. A phase accumulator adds a programmable step to an 11-bit phase every base cycle. The serial clock is at its active level while the phase is in the upper half of its 2048-count circle. The output rate is therefore the base rate times the step divided by 2048, and the rate does not need to be an integer fraction of the base clock. Software chooses the step as ceil(2048 / ceil(base_rate / target_rate)).

Beside the clock itself, the block gives the data shifter two single-cycle strobes: one in the cycle the clock leaves its idle level, and one in the cycle it returns to it. A per-profile option resets the phase at each transfer start. With that option, the first edge of every transfer falls a fixed number of base cycles after the start. A combinational flag reports when the programmed rate is above the synchronous capture limit. The surrounding logic uses that flag to select the asynchronous input-capture path.

Top module: `sclk_frac_gen`

## Requirements
- R1: While reset is asserted, and until it has been released synchronously, `sclk` equals `cpol`, and `lead_stb` and `trail_stb` are low.
- R2: While running, the phase advances by the effective step modulo 2048 on every base clock. Exactly k cycles after a phase clear, `sclk` equals `cpol` XOR bit 10 of (k × step mod 2048).
- R3: `lead_stb` is high for one cycle in each cycle where `sclk` moves from idle to active, and `trail_stb` in each cycle where it moves back. The two strobes are never high together. k cycles after a phase clear, the number of lead strobes seen is floor((k×step+1024)/2048) and the number of trail strobes is floor(k×step/2048).
- R4: When `xfer_start` is high and `restart_en` is high at a clock edge, the phase is cleared. In the following cycle `sclk` is idle and no strobe is produced, even when an edge was due in that cycle.
- R5: When `restart_en` is low, a `xfer_start` pulse has no effect on the phase, the clock or the strobes.
- R6: A `freq_word` of zero holds `sclk` at its idle level, with no strobes.
- R7: With `gate_en` low, `sclk` is idle, no strobes are produced and the phase is held at zero. Raising `gate_en` again therefore behaves like a restart.
- R8: The effective step is min(`freq_word`, 1024). Any larger word gives a clock at half the base rate, which toggles every cycle.
- R9: `fast_rate` is high exactly when step × BASE_HZ > SYNC_LIMIT_HZ × 2048. With the default 400 MHz base and 25 MHz limit, this means a word above 128.
- R10: `cpol` sets the idle level of `sclk` combinationally. `sclk` is active when it differs from `cpol`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_en | input | 1 | Lets the serial clock run |
| cpol | input | 1 | Idle level of the serial clock |
| restart_en | input | 1 | Profile option: clear the phase on transfer start |
| xfer_start | input | 1 | One-cycle transfer start pulse |
| freq_word | input | FREQ_W | Phase step per base cycle (rate = base × word / 2048) |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | Pulse in the cycle sclk leaves idle |
| trail_stb | output | 1 | Pulse in the cycle sclk returns to idle |
| fast_rate | output | 1 | Rate is above the synchronous capture limit |

## Verification
A phase clear, whether from a transfer restart or from the gate dropping, can fall in the same cycle as a clock edge that the accumulator would otherwise produce. The bench provokes this with a step of 1024, where every cycle carries an edge, and it also restarts at arbitrary phases, including while `sclk` is active. The clear is judged to win when, in the following cycle, the clock is idle and neither strobe is high. The strobe and level counts that follow must then match the closed-form values counted from that clear.

// File: rtl/sclk_frac_pkg.sv
package sclk_frac_pkg;
  typedef struct packed {
    logic lead;
    logic trail;
  } sclk_edge_t;
endpackage

// File: rtl/sclk_step_sel.sv
module sclk_step_sel #(
  parameter int FREQ_W  = 14,
  parameter int PHASE_W = 11
) (
  input  logic [FREQ_W-1:0]  freq_word,
  output logic [PHASE_W-1:0] step,
  output logic               step_zero
);
  localparam int HALF = 1 << (PHASE_W - 1);

  generate
    if (FREQ_W >= PHASE_W) begin : g_clamp
      always_comb begin
        if (freq_word > FREQ_W'(HALF)) step = PHASE_W'(HALF);
        else                           step = PHASE_W'(freq_word);
      end
    end else begin : g_pass
      always_comb step = PHASE_W'(freq_word);
    end
  endgenerate

  always_comb step_zero = (step == '0);
endmodule

// File: rtl/sclk_phase_acc.sv
module sclk_phase_acc #(
  parameter int PHASE_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               clear,
  input  logic [PHASE_W-1:0] step,
  output logic               half_nxt
);
  localparam int SUM_W = PHASE_W + 1;

  logic [PHASE_W-1:0] phase_q;
  logic [PHASE_W-1:0] phase_d;
  logic [SUM_W-1:0]   sum;

  always_comb begin
    sum     = {1'b0, phase_q} + {1'b0, step};
    phase_d = phase_q;
    if (clear)    phase_d = '0;
    else if (run) phase_d = sum[PHASE_W-1:0];
    half_nxt = phase_d[PHASE_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/sclk_edge_gen.sv
module sclk_edge_gen
  import sclk_frac_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       half_nxt,
  output logic       half_q,
  output sclk_edge_t edge_q
);
  logic       half_d;
  sclk_edge_t edge_d;

  always_comb begin
    half_d     = clear ? 1'b0 : half_nxt;
    edge_d     = '0;
    if (!clear) begin
      edge_d.lead  = !half_q &&  half_nxt;
      edge_d.trail =  half_q && !half_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      edge_q <= '0;
    end else begin
      half_q <= half_d;
      edge_q <= edge_d;
    end
  end
endmodule

// File: rtl/sclk_rate_flag.sv
module sclk_rate_flag #(
  parameter int          PHASE_W       = 11,
  parameter int unsigned BASE_HZ       = 400_000_000,
  parameter int unsigned SYNC_LIMIT_HZ = 25_000_000
) (
  input  logic [PHASE_W-1:0] step,
  output logic               fast_rate
);
  localparam logic [63:0] LIMIT_SCALED = 64'(SYNC_LIMIT_HZ) << PHASE_W;

  logic [63:0] rate_scaled;

  always_comb begin
    rate_scaled = 64'(step) * 64'(BASE_HZ);
    fast_rate   = rate_scaled > LIMIT_SCALED;
  end
endmodule

// File: rtl/sclk_frac_gen.sv
module sclk_frac_gen
  import sclk_frac_pkg::*;
#(
  parameter int          FREQ_W        = 14,
  parameter int          PHASE_W       = 11,
  parameter int unsigned BASE_HZ       = 400_000_000,
  parameter int unsigned SYNC_LIMIT_HZ = 25_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_en,
  input  logic              cpol,
  input  logic              restart_en,
  input  logic              xfer_start,
  input  logic [FREQ_W-1:0] freq_word,
  output logic              sclk,
  output logic              lead_stb,
  output logic              trail_stb,
  output logic              fast_rate
);
  logic [1:0]         rst_sync_q;
  logic               core_rst_n;
  logic [PHASE_W-1:0] step;
  logic               step_zero;
  logic               run;
  logic               clear;
  logic               half_nxt;
  logic               half_q;
  sclk_edge_t         edge_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  sclk_step_sel #(.FREQ_W(FREQ_W), .PHASE_W(PHASE_W)) u_step (
    .freq_word (freq_word),
    .step      (step),
    .step_zero (step_zero)
  );

  always_comb begin
    run   = gate_en && !step_zero;
    clear = !run || (restart_en && xfer_start);
  end

  sclk_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .run      (run),
    .clear    (clear),
    .step     (step),
    .half_nxt (half_nxt)
  );

  sclk_edge_gen u_edge (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .clear    (clear),
    .half_nxt (half_nxt),
    .half_q   (half_q),
    .edge_q   (edge_q)
  );

  sclk_rate_flag #(
    .PHASE_W(PHASE_W), .BASE_HZ(BASE_HZ), .SYNC_LIMIT_HZ(SYNC_LIMIT_HZ)
  ) u_flag (
    .step      (step),
    .fast_rate (fast_rate)
  );

  assign sclk      = cpol ^ half_q;
  assign lead_stb  = edge_q.lead;
  assign trail_stb = edge_q.trail;
endmodule

// File: rtl/sclk_frac_gen_chk.sv
module sclk_frac_gen_chk #(
  parameter int FREQ_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gate_en,
  input logic              cpol,
  input logic              restart_en,
  input logic              xfer_start,
  input logic [FREQ_W-1:0] freq_word,
  input logic              sclk,
  input logic              lead_stb,
  input logic              trail_stb,
  input logic              fast_rate
);
  // R3: strobes are exclusive
  p_no_dual_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_stb && trail_stb));

  // R3: a lead strobe coincides with the active level
  p_lead_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lead_stb |-> (sclk != cpol));

  // R3: a trail strobe coincides with the idle level
  p_trail_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trail_stb |-> (sclk == cpol));

  // R4: restart leaves the next cycle idle and quiet
  p_restart_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_en && xfer_start) |=> (sclk == cpol) && !lead_stb && !trail_stb);

  // R6: zero word stops at idle
  p_zero_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_word == '0) |=> (sclk == cpol) && !lead_stb && !trail_stb);

  // R7: gate low stops at idle
  p_gate_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |=> (sclk == cpol) && !lead_stb && !trail_stb);

  // R9: a zero rate is never above the limit
  p_zero_not_fast_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_word == '0) |-> !fast_rate);
endmodule

bind sclk_frac_gen sclk_frac_gen_chk #(.FREQ_W(FREQ_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .gate_en    (gate_en),
  .cpol       (cpol),
  .restart_en (restart_en),
  .xfer_start (xfer_start),
  .freq_word  (freq_word),
  .sclk       (sclk),
  .lead_stb   (lead_stb),
  .trail_stb  (trail_stb),
  .fast_rate  (fast_rate)
);

// File: tb/tb_sclk_frac_gen.sv
module tb_sclk_frac_gen;
  localparam int FREQ_W = 14;
  localparam longint BASE = 400_000_000;
  localparam longint LIMIT = 25_000_000;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              gate_en;
  logic              cpol;
  logic              restart_en;
  logic              xfer_start;
  logic [FREQ_W-1:0] freq_word;
  logic              sclk, lead_stb, trail_stb, fast_rate;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  sclk_frac_gen dut (
    .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .cpol(cpol),
    .restart_en(restart_en), .xfer_start(xfer_start), .freq_word(freq_word),
    .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb), .fast_rate(fast_rate)
  );

  always #5 clk = ~clk;

  function automatic longint eff(input longint w);
    return (w > 1024) ? 1024 : w;
  endfunction
  function automatic logic half_at(input longint k, input longint s);
    return logic'(((k * s) % 2048) >> 10);
  endfunction
  function automatic longint lead_cnt(input longint k, input longint s);
    return (k * s + 1024) / 2048;
  endfunction
  function automatic longint trail_cnt(input longint k, input longint s);
    return (k * s) / 2048;
  endfunction
  function automatic logic fast_exp(input longint w);
    return (eff(w) * BASE) > (LIMIT * 2048);
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      if (errors < 30) $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_idle(input string tag);
    chk(tag, sclk, cpol);
    chk(tag, lead_stb, 0);
    chk(tag, trail_stb, 0);
  endtask

  // Run from a restart; optional ignored start pulse at cycle hold_at (R5)
  task automatic run_case(input int w, input bit pol, input int n, input int hold_at);
    longint s;
    s = eff(w);
    @(negedge clk);
    freq_word = FREQ_W'(w); cpol = pol; gate_en = 1'b1;
    restart_en = 1'b1; xfer_start = 1'b1;
    #1 chk("R9 fast flag", fast_rate, fast_exp(w));
    @(negedge clk);
    xfer_start = 1'b0;
    check_idle("R4 restart cycle idle");
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (hold_at > 0 && k > hold_at) begin
        chk("R5 ignored start sclk", sclk, pol ^ half_at(k, s));
        chk("R5 ignored start lead", lead_stb, lead_cnt(k, s) - lead_cnt(k - 1, s));
      end else begin
        chk(w > 1024 ? "R8 clamp sclk" : "R2 sclk level", sclk, pol ^ half_at(k, s));
        chk("R3 lead strobe", lead_stb, lead_cnt(k, s) - lead_cnt(k - 1, s));
        chk("R3 trail strobe", trail_stb, trail_cnt(k, s) - trail_cnt(k - 1, s));
      end
      if (k == hold_at) begin restart_en = 1'b0; xfer_start = 1'b1; end
      if (hold_at > 0 && k == hold_at + 1) begin xfer_start = 1'b0; restart_en = 1'b1; end
    end
  endtask

  // Drop the gate, stay idle, re-enable: count restarts from zero (R7)
  task automatic gate_case(input int n);
    longint s;
    s = eff(freq_word);
    @(negedge clk);
    gate_en = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check_idle("R7 gate off idle");
    end
    gate_en = 1'b1;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      chk("R7 re-enable sclk", sclk, cpol ^ half_at(k, s));
      chk("R7 re-enable lead", lead_stb, lead_cnt(k, s) - lead_cnt(k - 1, s));
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; gate_en = 1'b0; cpol = 1'b0; restart_en = 1'b0;
    xfer_start = 1'b0; freq_word = '0;
    repeat (3) @(negedge clk);
    check_idle("R1 reset");
    gate_en = 1'b1; freq_word = 14'd700;
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 sync release");

    // R10 polarity idle level and R9 boundary
    run_case(128, 1'b1, 40, 0);
    run_case(129, 1'b0, 40, 0);
    // R4 restart coinciding with every-cycle edges
    run_case(1024, 1'b0, 12, 0);
    run_case(1024, 1'b1, 7, 0);
    run_case(1024, 1'b0, 10, 0);
    // R8 clamp
    run_case(2000, 1'b0, 10, 0);
    run_case(16383, 1'b1, 10, 0);
    // slow word: first lead strobe at cycle 1024
    run_case(1, 1'b0, 1100, 0);
    run_case(683, 1'b1, 60, 0);
    // R5 ignored start pulse
    run_case(300, 1'b0, 80, 17);
    // R7 gate drop and resume
    run_case(500, 1'b1, 11, 0);
    gate_case(50);

    // R6 zero word
    @(negedge clk);
    freq_word = '0;
    #1 chk("R9 zero word flag", fast_rate, 0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check_idle("R6 zero word idle");
    end

    // random mix
    for (int r = 0; r < 24; r++) begin
      int w, n;
      w = (r % 6 == 5) ? int'($urandom_range(1025, 16383)) : int'($urandom_range(4, 1024));
      n = int'(4096 / eff(w)) + 20;
      if (n > 1200) n = 1200;
      run_case(w, 1'($urandom_range(0, 1)), n, (r % 4 == 3) ? n / 2 : 0);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule